// File: doc/BRIEF.md
# Audio Sample Formatter and Buffer

This block sits between a host or DMA engine and a two-channel audio serializer. The host writes 32-bit data words through a small register write port. Each word holds one audio sample, and its layout is described by a mode register: how many bytes the sample occupies, how many of its bits are valid, whether its bytes are stored least or most significant first, and whether the sample sits at the low or high end of the word. On the way in, every accepted word is converted into a left-aligned 24-bit sample and placed in a per-channel buffer. The serializer then pulls samples one channel at a time through a request handshake.

In dual-channel mode, successive data writes alternate between channel 1 and channel 2, starting with channel 1. In mono mode, each write feeds both channels. A write that would land in a full buffer is dropped and sets a sticky overflow flag. A request made on an empty channel returns zero and sets that channel's sticky underrun flag. A packed status vector reports write readiness, emptiness, fullness, a chunk-space indication, and the per-channel ready and underrun state. Two control bits give a buffer clear and a full block reset.

Top module: `audio_sample_packer`

## Requirements
- R1: After `rst_n` is released, `mode_o` is zero, `sample_vld_o` is low and `status_o` is 13'h00B (ready, empty and chunk set; everything else clear).
- R2: A write with `wr_sel`=1 loads the mode register, and `mode_o` reads it back. The layout is: bit 0 enable, bit 1 dual, bit 2 big-endian, bit 3 high-end placement, bits 5:4 transfer mode, bits 13:8 valid bits, bits 19:16 chunk, bits 29:28 bytes minus one. All other bits read as zero.
- R3: In dual mode, data writes (`wr_sel`=2) go alternately to channel 1 (`req_chan`=0) and channel 2 (`req_chan`=1), starting with channel 1. Each channel returns its samples in write order.
- R4: In mono mode (bit 1 = 0), each accepted data write pushes the same sample into both channels.
- R5: With low-end placement and little-endian order, the container is the low N bytes of the word, where N = bytes-minus-one + 1. The sample is the low V bits of the container (V = the valid-bits field), left-aligned into 24 bits.
- R6: With big-endian order, the N bytes of the container are reversed before the valid bits are taken.
- R7: With high-end placement (bit 3 = 1), the container is the top N bytes of the word.
- R8: When V < 24, the low 24-V bits of the sample are zero. When V > 24, only the top 24 of the V bits are kept.
- R9: The target of a data write is the next channel in dual mode, or both channels in mono mode. A data write to a full target is dropped, does not advance the alternation, and sets the sticky overflow flag (`status_o` bit 5). Full (bit 2) shows that the target is full, and ready (bit 0) shows that it is not.
- R10: While enabled, a request on an empty channel produces `sample_vld_o` with a zero sample. It sets that channel's sticky underrun flag (bit 11 for channel 1, bit 12 for channel 2) and the combined underrun flag (bit 4). Channel-ready bits 8 and 9 show that a channel is non-empty, and empty (bit 1) shows that both channels are empty.
- R11: Chunk (bit 3) is set when the free entries in the write target are at least the chunk field.
- R12: A request is answered one cycle later with `sample_vld_o` only when enable is set. While enable is clear, requests neither pop samples nor set underrun.
- R13: A control write (`wr_sel`=0) with bit 1 set empties both channels and restarts the alternation at channel 1, and the mode is kept. A control write with bit 0 set also clears the mode and the sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 mode, 2 data, 3 ignored |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Sample request from the serializer |
| req_chan | input | 1 | Requested channel: 0 channel 1, 1 channel 2 |
| sample_o | output | SAMPLE_W | Left-aligned sample answering the last request |
| sample_vld_o | output | 1 | sample_o answers a request made one cycle earlier |
| status_o | output | 13 | Packed status flags |
| mode_o | output | 32 | Mode register readback |

## Verification
The bench builds the block with its defaults: a depth of 4 per channel and 24-bit samples. With this depth, nine writes fill both channels and push one more write into overflow. Chunk thresholds of 0, 3 and 4 are also all reachable, so the comparison between free space and the threshold can be tested on both sides. The 24-bit width lets each valid-bit count in the set 8, 16, 20, 24 and 32 be tested for zero fill or truncation, across every byte count, byte order and placement.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned STAT_W = 13;

  localparam int unsigned ST_READY  = 0;
  localparam int unsigned ST_EMPTY  = 1;
  localparam int unsigned ST_FULL   = 2;
  localparam int unsigned ST_CHUNK  = 3;
  localparam int unsigned ST_UNDER  = 4;
  localparam int unsigned ST_OVER   = 5;
  localparam int unsigned ST_CHRDY0 = 8;
  localparam int unsigned ST_CHUND0 = 11;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } asp_sel_e;

  typedef struct packed {
    logic [1:0] bytes_m1;
    logic [3:0] chunk;
    logic [5:0] vbits;
    logic [1:0] xfer;
    logic       hi_place;
    logic       big;
    logic       dual;
    logic       en;
  } asp_mode_t;

  function automatic asp_mode_t word_to_mode(input logic [WORD_W-1:0] w);
    asp_mode_t m;
    m.en       = w[0];
    m.dual     = w[1];
    m.big      = w[2];
    m.hi_place = w[3];
    m.xfer     = w[5:4];
    m.vbits    = w[13:8];
    m.chunk    = w[19:16];
    m.bytes_m1 = w[29:28];
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] mode_to_word(input asp_mode_t m);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[0]     = m.en;
    w[1]     = m.dual;
    w[2]     = m.big;
    w[3]     = m.hi_place;
    w[5:4]   = m.xfer;
    w[13:8]  = m.vbits;
    w[19:16] = m.chunk;
    w[29:28] = m.bytes_m1;
    return w;
  endfunction

endpackage

// File: rtl/asp_mode_reg.sv
module asp_mode_reg
  import asp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  output asp_mode_t         mode
);

  asp_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (soft_rst)  mode_d = '0;
    else if (load) mode_d = word_to_mode(load_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_rst) |=> (mode_to_word(mode) == ($past(load_data) & 32'h300F3F3F)));

endmodule

// File: rtl/asp_formatter.sv
module asp_formatter
  import asp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [WORD_W-1:0]   word,
  input  asp_mode_t           mode,
  output logic [SAMPLE_W-1:0] sample
);

  localparam logic [5:0] SW = 6'(SAMPLE_W);

  logic [2:0]        nbytes;
  logic [5:0]        cont_bits;
  logic [5:0]        vb;
  logic [WORD_W-1:0] cont;
  logic [WORD_W-1:0] cont_m;
  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] valid_v;
  logic [WORD_W-1:0] aligned;

  always_comb begin
    nbytes    = {1'b0, mode.bytes_m1} + 3'd1;
    cont_bits = {nbytes, 3'b000};
    vb        = (mode.vbits > 6'd32) ? 6'd32 : mode.vbits;

    // Select the container at the low or high end of the word.
    cont   = mode.hi_place ? (word >> (6'd32 - cont_bits)) : word;
    cont_m = cont & ((32'd1 << cont_bits) - 32'd1);

    // Reverse the container's bytes for big-endian order.
    swapped = {cont_m[7:0], cont_m[15:8], cont_m[23:16], cont_m[31:24]}
              >> (6'd32 - cont_bits);
    ordered = mode.big ? swapped : cont_m;

    // Keep the valid bits, then left-align into the sample width.
    valid_v = ordered & ((32'd1 << vb) - 32'd1);
    if (vb >= SW) aligned = valid_v >> (vb - SW);
    else          aligned = valid_v << (SW - vb);
    sample = aligned[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/asp_fifo.sv
module asp_fifo #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 din,
  input  logic                             pop,
  output logic [WIDTH-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]       count
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/audio_sample_packer.sv
module audio_sample_packer
  import asp_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [1:0]          wr_sel,
  input  logic [31:0]         wr_data,
  input  logic                req_valid,
  input  logic                req_chan,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic [12:0]         status_o,
  output logic [31:0]         mode_o
);

  localparam int unsigned NCH = 2;
  localparam int unsigned CW  = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  asp_mode_t           mode;
  logic                ctl_wr, soft_rst, buf_clr, mode_wr, data_wr;
  logic [SAMPLE_W-1:0] fmt_sample;
  logic [CW-1:0]       cnt  [NCH];
  logic [SAMPLE_W-1:0] head [NCH];
  logic [NCH-1:0]      push, pop, ch_nonempty;
  logic                tgt_full, accept, req_live;
  logic [CW-1:0]       tgt_cnt, free_cnt;

  logic                tog_q, tog_d;
  logic                ovf_q, ovf_d;
  logic [NCH-1:0]      und_q, und_d;
  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic                vld_q, vld_d;

  assign ctl_wr   = wr_valid && (asp_sel_e'(wr_sel) == SEL_CTRL);
  assign mode_wr  = wr_valid && (asp_sel_e'(wr_sel) == SEL_MODE);
  assign data_wr  = wr_valid && (asp_sel_e'(wr_sel) == SEL_DATA);
  assign soft_rst = ctl_wr && wr_data[0];
  assign buf_clr  = ctl_wr && (wr_data[0] || wr_data[1]);

  asp_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .load      (mode_wr),
    .load_data (wr_data),
    .mode      (mode)
  );

  asp_formatter #(.SAMPLE_W(SAMPLE_W)) u_fmt (
    .word   (wr_data),
    .mode   (mode),
    .sample (fmt_sample)
  );

  // Write target: the next channel in dual mode, both channels in mono.
  always_comb begin
    if (mode.dual) tgt_cnt = cnt[tog_q];
    else           tgt_cnt = (cnt[0] > cnt[1]) ? cnt[0] : cnt[1];
    tgt_full = (tgt_cnt == FULL_CNT);
    free_cnt = FULL_CNT - tgt_cnt;
    accept   = data_wr && !tgt_full;
    req_live = req_valid && mode.en;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign push[g]        = accept && (!mode.dual || (tog_q == g[0]));
    assign ch_nonempty[g] = (cnt[g] != '0);
    assign pop[g]         = req_live && (req_chan == g[0]) && ch_nonempty[g];

    asp_fifo #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (buf_clr),
      .push  (push[g]),
      .din   (fmt_sample),
      .pop   (pop[g]),
      .dout  (head[g]),
      .count (cnt[g])
    );
  end

  always_comb begin
    tog_d = tog_q;
    ovf_d = ovf_q;
    und_d = und_q;
    smp_d = smp_q;
    vld_d = 1'b0;
    if (accept && mode.dual) tog_d = ~tog_q;
    if (data_wr && tgt_full) ovf_d = 1'b1;
    if (req_live) begin
      vld_d = 1'b1;
      if (ch_nonempty[req_chan]) begin
        smp_d = head[req_chan];
      end else begin
        smp_d           = '0;
        und_d[req_chan] = 1'b1;
      end
    end
    if (buf_clr) tog_d = 1'b0;
    if (soft_rst) begin
      ovf_d = 1'b0;
      und_d = '0;
      smp_d = '0;
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      ovf_q <= 1'b0;
      und_q <= '0;
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      ovf_q <= ovf_d;
      und_q <= und_d;
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    status_o                         = '0;
    status_o[ST_READY]               = !tgt_full;
    status_o[ST_EMPTY]               = !(|ch_nonempty);
    status_o[ST_FULL]                = tgt_full;
    status_o[ST_CHUNK]               = (32'(free_cnt) >= 32'(mode.chunk));
    status_o[ST_UNDER]               = |und_q;
    status_o[ST_OVER]                = ovf_q;
    status_o[ST_CHRDY0 +: NCH]       = ch_nonempty;
    status_o[ST_CHUND0 +: NCH]       = und_q;
  end

  assign sample_o     = smp_q;
  assign sample_vld_o = vld_q;
  assign mode_o       = mode_to_word(mode);

  assert_req_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode.en && !soft_rst) |=> sample_vld_o);
  assert_req_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && mode.en) |=> !sample_vld_o);
  assert_underrun_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode.en && !ctl_wr && (cnt[req_chan] == '0))
      |=> (sample_o == '0) && status_o[ST_UNDER]);
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tgt_full) |=> status_o[ST_OVER]);
  assert_soft_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_o == 13'h00B) && (mode_o == '0) && !sample_vld_o);
  assert_mono_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode.dual) |-> (push == 2'b11));

endmodule

// File: tb/audio_sample_packer_tb_top.sv
module audio_sample_packer_tb_top;

  localparam int D  = 4;
  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [1:0]    wr_sel;
  logic [31:0]   wr_data;
  logic          req_valid;
  logic          req_chan;
  logic [SW-1:0] sample_o;
  logic          sample_vld_o;
  logic [12:0]   status_o;
  logic [31:0]   mode_o;

  audio_sample_packer #(.DEPTH(D), .SAMPLE_W(SW)) dut_i (
    .clk, .rst_n, .wr_valid, .wr_sel, .wr_data, .req_valid, .req_chan,
    .sample_o, .sample_vld_o, .status_o, .mode_o
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model state.
  logic [SW-1:0] q0[$], q1[$];
  logic [SW-1:0] sb[$];
  string         sb_tag[$];
  bit            m_en, m_dual, m_big, m_hi, tog, ovf;
  bit [1:0]      und;
  int            m_vb, m_chunk, m_nb;
  logic [31:0]   m_word;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_fmt(logic [31:0] w);
    logic [7:0]  by [4];
    logic [63:0] c, v, s;
    int          base;
    base = m_hi ? (4 - m_nb) : 0;
    for (int k = 0; k < 4; k++) by[k] = (k < m_nb) ? w[8*(base+k) +: 8] : 8'h00;
    c = '0;
    for (int k = 0; k < m_nb; k++)
      c = c | (64'(m_big ? by[m_nb-1-k] : by[k]) << (8*k));
    v = c & ((64'd1 << m_vb) - 64'd1);
    if (m_vb >= SW) s = v >> (m_vb - SW);
    else            s = v << (SW - m_vb);
    return s[SW-1:0];
  endfunction

  function automatic logic [12:0] ref_status();
    logic [12:0] st;
    int s0, s1, t, fr;
    bit tf;
    s0 = q0.size(); s1 = q1.size();
    if (m_dual) t = tog ? s1 : s0;
    else        t = (s0 > s1) ? s0 : s1;
    tf = (t == D);
    fr = D - t;
    st = '0;
    st[0] = !tf; st[1] = (s0 == 0) && (s1 == 0); st[2] = tf;
    st[3] = (fr >= m_chunk); st[4] = |und; st[5] = ovf;
    st[8] = (s0 != 0); st[9] = (s1 != 0);
    st[11] = und[0]; st[12] = und[1];
    return st;
  endfunction

  task automatic bus_write(logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic set_mode(bit en, bit dual, bit big, bit hi, int vb, int chunk, int nb);
    m_en = en; m_dual = dual; m_big = big; m_hi = hi;
    m_vb = vb; m_chunk = chunk; m_nb = nb;
    m_word = {2'b00, 2'(nb-1), 8'h00, 4'(chunk), 2'b00, 6'(vb), 2'b00, 2'b01,
              hi, big, dual, en};
    bus_write(2'd1, m_word);
  endtask

  task automatic data_write(logic [31:0] w);
    logic [SW-1:0] s;
    s = ref_fmt(w);
    if (m_dual) begin
      if ((tog ? q1.size() : q0.size()) < D) begin
        if (tog) q1.push_back(s); else q0.push_back(s);
        tog = ~tog;
      end else ovf = 1'b1;
    end else begin
      if (q0.size() < D && q1.size() < D) begin
        q0.push_back(s); q1.push_back(s);
      end else ovf = 1'b1;
    end
    bus_write(2'd2, w);
  endtask

  task automatic request(bit ch, string tag);
    logic [SW-1:0] e;
    if (m_en) begin
      if (ch == 1'b0 && q0.size() != 0)      e = q0.pop_front();
      else if (ch == 1'b1 && q1.size() != 0) e = q1.pop_front();
      else begin e = '0; und[ch] = 1'b1; end
      sb.push_back(e); sb_tag.push_back(tag);
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_chan = ch;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    while (q0.size() != 0 || q1.size() != 0) begin
      if (q0.size() != 0) request(1'b0, tag);
      if (q1.size() != 0) request(1'b1, tag);
    end
  endtask

  task automatic chk_status(string req);
    check(req, 32'(status_o), 32'(ref_status()));
  endtask

  // Monitor: compares each answered request against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && sample_vld_o) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12: unexpected sample %h expected none", sample_o);
      end else begin
        string t;
        t = sb_tag.pop_front();
        check(t, 32'(sample_o), 32'(sb.pop_front()));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_sel = 2'd3; wr_data = '0;
    req_valid = 1'b0; req_chan = 1'b0;
    m_en = 0; m_dual = 0; m_big = 0; m_hi = 0; m_vb = 0; m_chunk = 0; m_nb = 1;
    tog = 0; ovf = 0; und = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    check("R1", 32'(status_o), 32'h00B);
    check("R1", mode_o, 32'h0);
    check("R1", 32'(sample_vld_o), 32'h0);

    // R2: mode readback with reserved bits masked
    bus_write(2'd1, 32'hFFFF_FFFF);
    check("R2", mode_o, 32'h300F_3F3F);
    bus_write(2'd0, 32'h1);
    m_en = 0; m_dual = 0; m_chunk = 0;
    check("R13", mode_o, 32'h0);

    // R3 R5: dual, little-endian, low-end, 2 bytes, 16 bits
    set_mode(1, 1, 0, 0, 16, 1, 2);
    check("R2", mode_o, m_word);
    data_write(32'hAAAA_1234); data_write(32'hBBBB_5678);
    data_write(32'hCCCC_9ABC); data_write(32'hDDDD_DEF0);
    chk_status("R3");
    request(0, "R3"); request(1, "R3"); request(0, "R5"); request(1, "R5");
    chk_status("R3");

    // R6: big-endian, 2 bytes
    set_mode(1, 1, 1, 0, 16, 1, 2);
    data_write(32'h0000_1234); data_write(32'hFFFF_A55A);
    drain("R6");
    // R7: high-end placement, 3 bytes, both orders
    set_mode(1, 1, 0, 1, 24, 1, 3);
    data_write(32'h1122_3344); data_write(32'hABCD_EF01);
    drain("R7");
    set_mode(1, 1, 1, 1, 24, 1, 3);
    data_write(32'h1122_3344); data_write(32'hABCD_EF01);
    drain("R7");
    // R8: truncation and zero fill
    set_mode(1, 1, 0, 0, 32, 1, 4);
    data_write(32'h8765_4321); data_write(32'hFEDC_BA98);
    drain("R8");
    set_mode(1, 1, 0, 0, 8, 1, 1);
    data_write(32'h1234_56C3); data_write(32'h0000_007F);
    drain("R8");
    set_mode(1, 1, 1, 0, 20, 1, 3);
    data_write(32'h000F_1234); data_write(32'h00AB_CDEF);
    drain("R8");

    // R4: mono feeds both channels
    set_mode(1, 0, 0, 0, 16, 1, 2);
    data_write(32'h0000_1111); data_write(32'h0000_2222);
    chk_status("R4");
    request(0, "R4"); request(1, "R4"); request(0, "R4"); request(1, "R4");
    chk_status("R4");

    // R9: overflow in dual mode
    set_mode(1, 1, 0, 0, 24, 1, 3);
    for (int i = 0; i < 2*D; i++) data_write(32'h0001_0000 + 32'(i));
    chk_status("R9");
    data_write(32'h00EE_EEEE);
    chk_status("R9");
    check("R9", 32'(status_o[5]), 32'h1);
    drain("R9");
    chk_status("R9");

    // R10: underrun on each channel
    request(1, "R10");
    chk_status("R10");
    request(0, "R10");
    chk_status("R10");

    // R11: chunk threshold
    bus_write(2'd0, 32'h1); m_en = 0; m_dual = 0; m_chunk = 0; tog = 0;
    ovf = 0; und = '0; q0.delete(); q1.delete();
    set_mode(1, 1, 0, 0, 16, 3, 2);
    chk_status("R11");
    data_write(32'h1); data_write(32'h2);
    chk_status("R11");
    data_write(32'h3); data_write(32'h4);
    chk_status("R11");
    set_mode(1, 1, 0, 0, 16, 4, 2);
    chk_status("R11");

    // R12: disabled requests are ignored
    set_mode(0, 1, 0, 0, 16, 0, 2);
    request(0, "R12"); request(1, "R12");
    chk_status("R12");
    set_mode(1, 1, 0, 0, 16, 0, 2);
    request(0, "R12");
    chk_status("R12");

    // R13: buffer clear keeps mode, full reset clears it
    bus_write(2'd0, 32'h2); q0.delete(); q1.delete(); tog = 0;
    chk_status("R13");
    check("R13", mode_o, m_word);
    data_write(32'h0000_0ACE);
    request(0, "R13");
    bus_write(2'd0, 32'h1);
    check("R13", mode_o, 32'h0);
    check("R13", 32'(status_o), 32'h00B);

    repeat (4) @(posedge clk);
    check("R12", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule